// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional

This block holds one address reservation for each of several hardware contexts that share memory, so that each context can build atomic read-modify-write sequences from a locked read followed by a conditional write. It sees one memory request per cycle. Each request carries a context number, a physical address, a direction, a locked flag and an uncacheable flag. A locked read takes out a reservation on the 16-byte block that holds its address. A later locked write from the same context checks that reservation to decide whether the write may reach memory.

For every request the block returns a registered response one cycle later. The response holds a two-bit conditional result code and a commit flag that tells the memory path whether the write goes ahead. Any write that commits removes every reservation on its block, in all contexts, so a competing store breaks a pending sequence. Each context also counts its consecutive conditional failures. A warning flag pulses each time that count reaches a whole multiple of a fixed period, which points to a likely livelock.

Top module: `resv_monitor`

## Requirements
- R1: After reset no context holds a reservation and all three outputs are 0, so a cacheable locked write issued first fails with code 0 and commit 0.
- R2: A locked read (write=0, locked=1) reserves the 16-byte block of its address for its context. A later cacheable locked write from that context to any address in the same block (address bits above bit 3 equal) returns code 1 with commit 1.
- R3: A cacheable locked write whose context has no reservation, or has one on a different block, returns code 0 with commit 0.
- R4: A failing locked write drops that context's reservation, so a retry to the originally reserved block also fails.
- R5: An uncacheable locked write returns code 2 with commit 1 whatever the reservation state, and resets that context's consecutive-failure count to zero.
- R6: Every committed write (plain write, successful conditional, uncacheable conditional) removes the reservation of every context whose reserved block equals the written block, the writer's own included. Reservations on other blocks are kept.
- R7: A successful conditional resets its context's consecutive-failure count to zero.
- R8: A plain read (write=0, locked=0) changes no reservation. It returns code 0 with commit 0.
- R9: A plain write (locked=0) returns code 0 with commit 1.
- R10: warn_pulse is 1 for exactly the response of the conditional failure that brings a context's consecutive-failure count to a multiple of WARN_PERIOD, and is 0 otherwise.
- R11: rsp_valid is 1 exactly one cycle after each cycle with req_valid=1. When rsp_valid is 0, rsp_commit and warn_pulse are 0.
- R12: Contexts are independent: a reservation taken by one context does not let another context's conditional write succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_ctx | input | $clog2(NCTX) | Requesting context |
| req_addr | input | ADDR_W | Physical address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_locked | input | 1 | Locked read or conditional write |
| req_uncached | input | 1 | Access is uncacheable |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_code | output | 2 | 0 fail, 1 success, 2 uncacheable conditional |
| rsp_commit | output | 1 | The write may proceed to memory |
| warn_pulse | output | 1 | Periodic consecutive-failure warning |

## Verification
The bench builds the block with four contexts, a 16-bit address and WARN_PERIOD set to 5. With that period, the warning wrap, and the way an uncacheable or successful conditional restarts the count, show up within a few requests. Random traffic is confined to four adjacent blocks with every low-bit offset. That choice makes cross-context clearing, matches at different offsets within a block, and mismatches on neighbouring blocks happen often. A reference model in the bench, written from the requirements, predicts every response, and directed sequences cover the named corners before the random sweep.

// File: rtl/resv_monitor_pkg.sv
package resv_monitor_pkg;
    typedef enum logic [1:0] {
        SC_FAIL     = 2'd0,
        SC_PASS     = 2'd1,
        SC_UNCACHED = 2'd2
    } sc_code_e;

    localparam int BLK_OFS_BITS = 4;
endpackage

// File: rtl/resv_slot.sv
module resv_slot #(
    parameter int BLK_W  = 28,
    parameter int PERIOD = 100000,
    localparam int PH_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] cmp_blk_i,
    output logic             hit_o,
    input  logic             set_i,
    input  logic             clear_i,
    input  logic             fail_i,
    input  logic             cnt_clr_i,
    output logic             warn_o
);
    typedef struct packed {
        logic             vld;
        logic [BLK_W-1:0] blk;
        logic [PH_W-1:0]  phase;
    } slot_t;

    slot_t slot_d, slot_q;

    assign hit_o = slot_q.vld && (slot_q.blk == cmp_blk_i);

    always_comb begin
        slot_d = slot_q;
        warn_o = 1'b0;
        // clearing first, so a same-cycle new reservation survives
        if (clear_i) slot_d.vld = 1'b0;
        if (set_i) begin
            slot_d.vld = 1'b1;
            slot_d.blk = cmp_blk_i;
        end
        if (cnt_clr_i) begin
            slot_d.phase = '0;
        end else if (fail_i) begin
            if (slot_q.phase == PH_W'(PERIOD - 1)) begin
                slot_d.phase = '0;
                warn_o       = 1'b1;
            end else begin
                slot_d.phase = slot_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end
endmodule

// File: rtl/sc_judge.sv
module sc_judge
    import resv_monitor_pkg::*;
(
    input  logic       valid_i,
    input  logic       write_i,
    input  logic       locked_i,
    input  logic       uncached_i,
    input  logic       own_hit_i,
    output logic [1:0] code_o,
    output logic       commit_o,
    output logic       fail_o,
    output logic       cnt_clr_o,
    output logic       reserve_o
);
    logic cond_wr;

    always_comb begin
        cond_wr   = valid_i && write_i && locked_i;
        code_o    = SC_FAIL;
        commit_o  = 1'b0;
        fail_o    = 1'b0;
        cnt_clr_o = 1'b0;
        reserve_o = valid_i && !write_i && locked_i;
        if (valid_i && write_i && !locked_i) begin
            commit_o = 1'b1;
        end else if (cond_wr && uncached_i) begin
            code_o    = SC_UNCACHED;
            commit_o  = 1'b1;
            cnt_clr_o = 1'b1;
        end else if (cond_wr && own_hit_i) begin
            code_o    = SC_PASS;
            commit_o  = 1'b1;
            cnt_clr_o = 1'b1;
        end else if (cond_wr) begin
            fail_o = 1'b1;
        end
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_monitor_pkg::*;
#(
    parameter int NCTX        = 4,
    parameter int ADDR_W      = 32,
    parameter int WARN_PERIOD = 100000,
    localparam int CTX_W      = $clog2(NCTX),
    localparam int BLK_W      = ADDR_W - BLK_OFS_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_locked,
    input  logic              req_uncached,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              rsp_commit,
    output logic              warn_pulse
);
    typedef struct packed {
        logic       vld;
        logic [1:0] code;
        logic       commit;
        logic       warn;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [BLK_W-1:0] req_blk;
    logic [NCTX-1:0]  hit, warn_vec;
    logic [1:0]       code;
    logic             commit, fail, cnt_clr, reserve, own_hit;

    assign req_blk = req_addr[ADDR_W-1:BLK_OFS_BITS];
    assign own_hit = hit[req_ctx];

    sc_judge u_judge (
        .valid_i    (req_valid),
        .write_i    (req_write),
        .locked_i   (req_locked),
        .uncached_i (req_uncached),
        .own_hit_i  (own_hit),
        .code_o     (code),
        .commit_o   (commit),
        .fail_o     (fail),
        .cnt_clr_o  (cnt_clr),
        .reserve_o  (reserve)
    );

    for (genvar g = 0; g < NCTX; g++) begin : g_slot
        logic mine;
        assign mine = (req_ctx == CTX_W'(g));
        resv_slot #(.BLK_W(BLK_W), .PERIOD(WARN_PERIOD)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmp_blk_i (req_blk),
            .hit_o     (hit[g]),
            .set_i     (reserve && mine),
            .clear_i   ((commit && hit[g]) || (fail && mine)),
            .fail_i    (fail && mine),
            .cnt_clr_i (cnt_clr && mine),
            .warn_o    (warn_vec[g])
        );
    end

    always_comb begin
        rsp_d.vld    = req_valid;
        rsp_d.code   = code;
        rsp_d.commit = commit;
        rsp_d.warn   = |warn_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.vld;
    assign rsp_code   = rsp_q.code;
    assign rsp_commit = rsp_q.commit;
    assign warn_pulse = rsp_q.warn;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int NCTX   = 4,
    parameter int ADDR_W = 32,
    localparam int CTX_W = $clog2(NCTX)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [CTX_W-1:0]  req_ctx,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              req_locked,
    input logic              req_uncached,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic              rsp_commit,
    input logic              warn_pulse
);
    a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r11_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r11_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_commit && !warn_pulse));
    a_r5_uncached_code: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_locked && req_uncached)
        |=> (rsp_code == 2'd2 && rsp_commit));
    a_r9_plain_write_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_locked) |=> (rsp_commit && rsp_code == 2'd0));
    a_r8_read_never_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (!rsp_commit && rsp_code == 2'd0));
    a_r10_warn_on_failure: assert property (@(posedge clk) disable iff (!rst_n)
        warn_pulse |-> (rsp_valid && rsp_code == 2'd0 && !rsp_commit));
    a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_code != 2'd3);
endmodule

bind resv_monitor resv_monitor_chk #(.NCTX(NCTX), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
    .req_addr(req_addr), .req_write(req_write), .req_locked(req_locked),
    .req_uncached(req_uncached), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_commit(rsp_commit), .warn_pulse(warn_pulse)
);

// File: tb/test_resv_monitor.sv
module test_resv_monitor;
    localparam int NCTX = 4;
    localparam int AW   = 16;
    localparam int PER  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_ctx = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0, req_locked = 1'b0, req_uncached = 1'b0;
    logic          rsp_valid, rsp_commit, warn_pulse;
    logic [1:0]    rsp_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic          mv [NCTX];
    logic [AW-5:0] mb [NCTX];
    int            mf [NCTX];
    logic [31:0]   seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    resv_monitor #(.NCTX(NCTX), .ADDR_W(AW), .WARN_PERIOD(PER)) i_resv_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
        .req_addr(req_addr), .req_write(req_write), .req_locked(req_locked),
        .req_uncached(req_uncached), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_commit(rsp_commit), .warn_pulse(warn_pulse)
    );

    task automatic chk(string tag, logic [4:0] got, logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got={v,code,commit,warn}=%b exp=%b", tag, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(string tag, int ctx, logic [AW-1:0] a, bit w, bit l, bit uc);
        logic [1:0]    ecode;
        bit            ecommit, ewarn, hit;
        logic [AW-5:0] blk;
        blk = a[AW-1:4];
        hit = mv[ctx] && (mb[ctx] == blk);
        ecode = 2'd0; ecommit = 1'b0; ewarn = 1'b0;
        if (!w) begin
            if (l) begin mv[ctx] = 1'b1; mb[ctx] = blk; end
        end else if (!l) begin
            ecommit = 1'b1;
        end else if (uc) begin
            ecode = 2'd2; ecommit = 1'b1; mf[ctx] = 0;
        end else if (hit) begin
            ecode = 2'd1; ecommit = 1'b1; mf[ctx] = 0;
        end else begin
            mv[ctx] = 1'b0; mf[ctx]++;
            ewarn = (mf[ctx] % PER) == 0;
        end
        if (ecommit)
            for (int i = 0; i < NCTX; i++)
                if (mv[i] && mb[i] == blk) mv[i] = 1'b0;
        req_valid = 1'b1; req_ctx = 2'(ctx); req_addr = a;
        req_write = w; req_locked = l; req_uncached = uc;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, {rsp_valid, rsp_code, rsp_commit, warn_pulse}, {1'b1, ecode, ecommit, ewarn});
    endtask

    task automatic idle_chk();
        @(negedge clk);
        chk("R11 idle", {rsp_valid, rsp_code, rsp_commit, warn_pulse}, 5'b0);
    endtask

    initial begin
        for (int i = 0; i < NCTX; i++) begin mv[i] = 1'b0; mb[i] = '0; mf[i] = 0; end
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {rsp_valid, rsp_code, rsp_commit, warn_pulse}, 5'b0);
        rst_n = 1'b1;
        step("R1 first conditional fails", 0, 16'h0100, 1, 1, 0);
        // R2: reserve then succeed at another offset of the block
        step("R2 locked read", 1, 16'h0234, 0, 1, 0);
        step("R2 conditional same block", 1, 16'h023C, 1, 1, 0);
        // R6/R7: the success removed its own reservation
        step("R6 own reservation gone", 1, 16'h0230, 1, 1, 0);
        // R3 and R4
        step("R3 locked read", 2, 16'h0400, 0, 1, 0);
        step("R3 other block fails", 2, 16'h0410, 1, 1, 0);
        step("R4 retry fails", 2, 16'h0400, 1, 1, 0);
        // R8: plain read keeps reservation
        step("R8 locked read", 0, 16'h0500, 0, 1, 0);
        step("R8 plain read", 0, 16'h0600, 0, 0, 0);
        step("R8 reservation kept", 0, 16'h050F, 1, 1, 0);
        // R6 cross-context clear and R9
        step("R6 ctx1 reserves", 1, 16'h0700, 0, 1, 0);
        step("R6 ctx2 reserves", 2, 16'h0800, 0, 1, 0);
        step("R9 plain write", 3, 16'h0705, 1, 0, 0);
        step("R6 ctx1 cleared", 1, 16'h0700, 1, 1, 0);
        step("R6 ctx2 kept", 2, 16'h0800, 1, 1, 0);
        // R12: another context cannot use a reservation
        step("R12 ctx0 reserves", 0, 16'h0900, 0, 1, 0);
        step("R12 ctx3 fails", 3, 16'h0900, 1, 1, 0);
        step("R12 ctx0 still ok", 0, 16'h0900, 1, 1, 0);
        idle_chk();
        // R5: uncached ignores reservation, clears matching blocks
        step("R5 ctx1 reserves", 1, 16'h0A00, 0, 1, 0);
        step("R5 uncached cond", 2, 16'h0A04, 1, 1, 1);
        step("R5 clears ctx1", 1, 16'h0A00, 1, 1, 0);
        // R10: warning wrap on ctx3, restarted by R5 and R7
        for (int k = 0; k < 12; k++) step("R10 fail run", 3, 16'h0B00, 1, 1, 0);
        step("R5 count reset", 3, 16'h0B00, 1, 1, 1);
        for (int k = 0; k < 4; k++) step("R10 after reset", 3, 16'h0B00, 1, 1, 0);
        step("R7 reserve", 3, 16'h0C00, 0, 1, 0);
        step("R7 success", 3, 16'h0C00, 1, 1, 0);
        for (int k = 0; k < 5; k++) step("R7 count restarted", 3, 16'h0C00, 1, 1, 0);
        idle_chk();
        // random sweep over four adjacent blocks
        for (int n = 0; n < 4000; n++) begin
            int op;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            op = int'(seed[12:10]);
            case (op)
                0, 1: step("R2 rnd lr",  int'(seed[1:0]), {10'h010, seed[5:0]}, 0, 1, 0);
                2:    step("R8 rnd rd",  int'(seed[1:0]), {10'h010, seed[5:0]}, 0, 0, 0);
                3:    step("R6 rnd wr",  int'(seed[1:0]), {10'h010, seed[5:0]}, 1, 0, 0);
                7:    step("R5 rnd uc",  int'(seed[1:0]), {10'h010, seed[5:0]}, 1, 1, 1);
                default: step("R3 rnd sc", int'(seed[1:0]), {10'h010, seed[5:0]}, 1, 1, 0);
            endcase
        end
        idle_chk();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog expired got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule